// File: doc/BRIEF.md
# Paced Block-Write Bus Issuer

This block is the sending side of a processor's multiplexed 64-bit address/data bus, for writes only. A local client hands it one request through a valid/ready handshake. The request carries an address, an 8-bit command, a block/single flag and up to four data words. The issuer then waits for the system's active-low write-ready line. When that line is low, it drives one address cycle and then the data beats. Every cycle it drives is marked with an active-low valid strobe. The bus carries an even-parity bit for each byte lane and a phase bit above the command.

A two-bit pacing code sets the number of idle cycles placed between the beats of a block write. The code is captured together with the request, so changing the input later has no effect on a transfer already in progress. During idle gaps the strobe is high and the bus lines hold their last value.

Top module: `wrblk_issuer`

## Requirements
- R1: In every driven cycle, `bus_cmd[8]` is 0 for the address cycle and 1 for each data beat. `bus_cmd[7:0]` equals the command of the accepted request.
- R2: `valid_out_n` is low only in the address cycle and in the data-beat cycles. It is high while idle, while waiting for write-ready, and in gap cycles.
- R3: In every driven cycle, `bus_par[i]` is the XOR of `bus_ad[8i+7:8i]`, so that each byte together with its parity bit has even parity.
- R4: The address cycle appears in the cycle after the first rising clock edge at which `wr_rdy_n` is sampled low after acceptance. While `wr_rdy_n` stays high, nothing is driven.
- R5: Data beat 0 directly follows the address cycle. The number of idle cycles between consecutive block beats follows the pacing code: 00 gives 0, 01 gives 1, 10 gives 2, 11 gives 3.
- R6: A block write (`req_block`=1) drives exactly four beats. Beat k carries `req_data[64k+63:64k]`, in order k=0..3. A single write drives one beat carrying word 0, and its timing is the same for every pacing code.
- R7: `req_ready` is high only when no request is in progress. A request is taken at a rising edge where both `req_valid` and `req_ready` are high. `req_ready` rises again in the cycle after the last beat.
- R8: The pacing code, address, command and data are captured at acceptance. Later changes to those inputs do not affect the transfer in progress.
- R9: After reset, `valid_out_n` and `req_ready` are high, and `bus_ad`, `bus_par` and `bus_cmd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Issuer can take a request |
| req_addr | input | 64 | Write address |
| req_cmd | input | 8 | Command bits placed on `bus_cmd[7:0]` |
| req_block | input | 1 | 1 = four-beat block, 0 = single beat |
| req_data | input | 256 | Four data words, word k at bits 64k+63:64k |
| pace_code | input | 2 | Idle cycles between block beats |
| wr_rdy_n | input | 1 | System ready for a write, active low |
| bus_ad | output | 64 | Multiplexed address/data |
| bus_par | output | 8 | Even parity per byte lane |
| bus_cmd | output | 9 | Phase bit (8) and command (7:0) |
| valid_out_n | output | 1 | Driven-cycle strobe, active low |

## Verification
The bound checker watches every cycle. It checks that lane parity matches the driven value, that an address cycle only follows a sampled-low write-ready, and that the first data beat comes right after the address. It also checks that no address cycle follows a data beat, that the command byte stays steady across a transfer, and that nothing is driven while the issuer reports ready. Other properties need the bench's behavioural model and its scenarios. These are the exact gap count for each pacing code, the beat count and word order, the length of the write-ready wait, the capture of the pacing code and data at acceptance, and the return of the handshake.

// File: rtl/wrblk_pkg.sv
package wrblk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_GAP  = 3'd4
  } wrblk_state_t;
endpackage

// File: rtl/wrblk_parity.sv
module wrblk_parity #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] word,
  output logic [LANES-1:0]  par
);
  // even parity per lane: the lane bits XOR the parity bit give zero
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ^word[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/wrblk_gap_timer.sv
module wrblk_gap_timer #(
  parameter int PACE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [PACE_W-1:0] gap_len,
  output logic              gap_last
);
  logic [PACE_W-1:0] cnt_q;
  logic [PACE_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = start | tick;
    if (start) begin
      cnt_d = gap_len;
    end else begin
      cnt_d = cnt_q - PACE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign gap_last = (cnt_q == PACE_W'(1));
endmodule

// File: rtl/wrblk_seq.sv
module wrblk_seq
  import wrblk_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             wr_rdy_n,
  input  logic             is_block,
  input  logic             pace_zero,
  input  logic             gap_last,
  output wrblk_state_t     state_q,
  output wrblk_state_t     state_d,
  output logic [IDX_W-1:0] beat_d,
  output logic             gap_start,
  output logic             gap_tick
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] beat_q;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    gap_start = 1'b0;
    gap_tick  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          state_d = ST_WAIT;
          beat_d  = '0;
        end
      end
      ST_WAIT: begin
        if (!wr_rdy_n) begin
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        state_d = ST_DATA;
        beat_d  = '0;
      end
      ST_DATA: begin
        if (!is_block || (beat_q == LAST_BEAT)) begin
          state_d = ST_IDLE;
        end else if (pace_zero) begin
          beat_d = beat_q + IDX_W'(1);
        end else begin
          state_d   = ST_GAP;
          gap_start = 1'b1;
        end
      end
      ST_GAP: begin
        gap_tick = 1'b1;
        if (gap_last) begin
          state_d = ST_DATA;
          beat_d  = beat_q + IDX_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end
endmodule

// File: rtl/wrblk_issuer.sv
module wrblk_issuer
  import wrblk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int CMD_W  = 8,
  parameter int BEATS  = 4,
  parameter int PACE_W = 2,
  localparam int LANES = DATA_W / LANE_W,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [DATA_W-1:0]       req_addr,
  input  logic [CMD_W-1:0]        req_cmd,
  input  logic                    req_block,
  input  logic [BEATS*DATA_W-1:0] req_data,
  input  logic [PACE_W-1:0]       pace_code,
  input  logic                    wr_rdy_n,
  output logic [DATA_W-1:0]       bus_ad,
  output logic [LANES-1:0]        bus_par,
  output logic [CMD_W:0]          bus_cmd,
  output logic                    valid_out_n
);
  wrblk_state_t state_q;
  wrblk_state_t state_d;
  logic [IDX_W-1:0] beat_d;
  logic gap_start;
  logic gap_tick;
  logic gap_last;
  logic req_fire;

  // captured request
  logic [DATA_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              blk_q;
  logic [PACE_W-1:0] pace_q;
  logic [DATA_W-1:0] data_q [BEATS];

  // output path
  logic              drive_addr;
  logic              drive_data;
  logic              out_en;
  logic [DATA_W-1:0] bus_d;
  logic [LANES-1:0]  par_d;
  logic [CMD_W:0]    cmd_d;
  logic [DATA_W-1:0] bus_q;
  logic [LANES-1:0]  par_q;
  logic [CMD_W:0]    cmd_q_out;
  logic              valid_n_q;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      blk_q  <= 1'b0;
      pace_q <= '0;
    end else if (req_fire) begin
      addr_q <= req_addr;
      cmd_q  <= req_cmd;
      blk_q  <= req_block;
      pace_q <= pace_code;
    end
  end

  for (genvar k = 0; k < BEATS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[k] <= '0;
      end else if (req_fire) begin
        data_q[k] <= req_data[k*DATA_W +: DATA_W];
      end
    end
  end

  wrblk_seq #(.BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .wr_rdy_n  (wr_rdy_n),
    .is_block  (blk_q),
    .pace_zero (pace_q == '0),
    .gap_last  (gap_last),
    .state_q   (state_q),
    .state_d   (state_d),
    .beat_d    (beat_d),
    .gap_start (gap_start),
    .gap_tick  (gap_tick)
  );

  wrblk_gap_timer #(.PACE_W(PACE_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (gap_start),
    .tick     (gap_tick),
    .gap_len  (pace_q),
    .gap_last (gap_last)
  );

  always_comb begin
    drive_addr = (state_d == ST_ADDR);
    drive_data = (state_d == ST_DATA);
    out_en     = drive_addr | drive_data;
    bus_d      = drive_addr ? addr_q : data_q[beat_d];
    cmd_d      = {drive_data, cmd_q};
  end

  wrblk_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
    .word (bus_d),
    .par  (par_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_n_q <= 1'b1;
    end else begin
      valid_n_q <= ~out_en;
    end
  end

  // bus lines only load in driven cycles and hold through gaps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q     <= '0;
      par_q     <= '0;
      cmd_q_out <= '0;
    end else if (out_en) begin
      bus_q     <= bus_d;
      par_q     <= par_d;
      cmd_q_out <= cmd_d;
    end
  end

  assign bus_ad      = bus_q;
  assign bus_par     = par_q;
  assign bus_cmd     = cmd_q_out;
  assign valid_out_n = valid_n_q;
endmodule

// File: rtl/wrblk_checker.sv
module wrblk_checker #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int CMD_W  = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_rdy_n,
  input logic              req_ready,
  input logic              valid_out_n,
  input logic [DATA_W-1:0] bus_ad,
  input logic [LANES-1:0]  bus_par,
  input logic [CMD_W:0]    bus_cmd
);
  function automatic logic [LANES-1:0] lane_par(input logic [DATA_W-1:0] w);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) begin
      p[i] = ^w[i*LANE_W +: LANE_W];
    end
    return p;
  endfunction

  logic addr_cyc;
  logic data_cyc;
  assign addr_cyc = !valid_out_n && !bus_cmd[CMD_W];
  assign data_cyc = !valid_out_n &&  bus_cmd[CMD_W];

  assert_lane_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out_n |-> (bus_par == lane_par(bus_ad)));

  assert_addr_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cyc |-> $past(!wr_rdy_n));

  assert_beat0_follows_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cyc |=> data_cyc);

  assert_no_addr_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_cyc |=> !addr_cyc);

  assert_cmd_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_out_n && $past(!valid_out_n)) |-> $stable(bus_cmd[CMD_W-1:0]));

  assert_quiet_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> valid_out_n);
endmodule

bind wrblk_issuer wrblk_checker #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W),
  .CMD_W  (CMD_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_rdy_n    (wr_rdy_n),
  .req_ready   (req_ready),
  .valid_out_n (valid_out_n),
  .bus_ad      (bus_ad),
  .bus_par     (bus_par),
  .bus_cmd     (bus_cmd)
);

// File: tb/test_wrblk_issuer.sv
module test_wrblk_issuer;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [63:0]  req_addr;
  logic [7:0]   req_cmd;
  logic         req_block;
  logic [255:0] req_data;
  logic [1:0]   pace_code;
  logic         wr_rdy_n;
  logic [63:0]  bus_ad;
  logic [7:0]   bus_par;
  logic [8:0]   bus_cmd;
  logic         valid_out_n;

  int checks = 0;
  int fails  = 0;
  int beats_seen = 0;

  wrblk_issuer i_wrblk_issuer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_block(req_block),
    .req_data(req_data), .pace_code(pace_code), .wr_rdy_n(wr_rdy_n),
    .bus_ad(bus_ad), .bus_par(bus_par), .bus_cmd(bus_cmd),
    .valid_out_n(valid_out_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------- behavioural reference: a schedule queue ----------
  int          m_mode = 0;            // 0 idle, 1 waiting, 2 transferring
  logic [63:0] m_addr;
  logic [7:0]  m_cmd;
  bit          m_blk;
  int          m_pace;
  logic [63:0] m_words [4];
  logic [63:0] q_ad  [$];
  bit          q_drv [$];
  bit          q_ph  [$];
  logic [63:0] e_ad;
  bit          e_drv = 0;
  bit          e_ph  = 0;

  task automatic pop_expect();
    e_ad  = q_ad.pop_front();
    e_drv = q_drv.pop_front();
    e_ph  = q_ph.pop_front();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; e_drv = 0; q_ad.delete(); q_drv.delete(); q_ph.delete();
    end else begin
      case (m_mode)
        0: begin
          e_drv = 0;
          if (req_valid) begin
            m_addr = req_addr; m_cmd = req_cmd; m_blk = req_block;
            m_pace = int'(pace_code);
            for (int k = 0; k < 4; k++) m_words[k] = req_data[k*64 +: 64];
            m_mode = 1;
          end
        end
        1: begin
          e_drv = 0;
          if (!wr_rdy_n) begin
            int n;
            n = m_blk ? 4 : 1;
            q_ad.push_back(m_addr); q_drv.push_back(1); q_ph.push_back(0);
            for (int k = 0; k < n; k++) begin
              q_ad.push_back(m_words[k]); q_drv.push_back(1); q_ph.push_back(1);
              if (k < n - 1)
                for (int g = 0; g < m_pace; g++) begin
                  q_ad.push_back('0); q_drv.push_back(0); q_ph.push_back(0);
                end
            end
            pop_expect();
            m_mode = 2;
          end
        end
        default: begin
          if (q_ad.size() > 0) pop_expect();
          else begin e_drv = 0; m_mode = 0; end
        end
      endcase
    end
  end

  function automatic logic [7:0] exp_par(input logic [63:0] w);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^w[i*8 +: 8];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (!valid_out_n && bus_cmd[8]) beats_seen++;
      check(valid_out_n == !e_drv, "R2/R4/R5", "valid_out_n", 64'(valid_out_n), 64'(!e_drv));
      check(req_ready == (m_mode == 0), "R7", "req_ready", 64'(req_ready), 64'(m_mode == 0));
      if (e_drv && !valid_out_n) begin
        check(bus_ad == e_ad, "R6/R8", "bus_ad", bus_ad, e_ad);
        check(bus_cmd[8] == e_ph, "R1", "phase bit", 64'(bus_cmd[8]), 64'(e_ph));
        check(bus_cmd[7:0] == m_cmd, "R1", "command", 64'(bus_cmd[7:0]), 64'(m_cmd));
        check(bus_par == exp_par(bus_ad), "R3", "parity", 64'(bus_par), 64'(exp_par(bus_ad)));
      end
    end
  end

  // ---------- stimulus ----------
  task automatic send(input bit blk, input logic [1:0] pace, input int hold, input bit keep);
    bit r;
    beats_seen = 0;
    req_addr  = {$urandom, $urandom};
    req_cmd   = 8'($urandom);
    req_block = blk;
    for (int k = 0; k < 4; k++) req_data[k*64 +: 64] = {$urandom, $urandom};
    pace_code = pace;
    wr_rdy_n  = 1'b1;
    req_valid = 1'b1;
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
    // R8: disturb captured inputs after acceptance
    req_valid = keep;
    pace_code = ~pace;
    req_addr  = ~req_addr;
    req_cmd   = ~req_cmd;
    req_data  = ~req_data;
    repeat (hold) @(negedge clk);
    wr_rdy_n = 1'b0;
    while (m_mode != 0) @(negedge clk);
    req_valid = 1'b0;
    wr_rdy_n  = 1'b1;
    check(beats_seen == (blk ? 4 : 1), "R6", "beat count",
          64'(beats_seen), 64'(blk ? 4 : 1));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0;
    req_block = 1'b0; req_data = '0; pace_code = '0; wr_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset values
    check(valid_out_n == 1'b1, "R9", "reset valid_out_n", 64'(valid_out_n), 64'd1);
    check(req_ready == 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
    check(bus_ad == '0 && bus_par == '0 && bus_cmd == '0, "R9", "reset bus",
          bus_ad ^ 64'(bus_par) ^ 64'(bus_cmd), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: every pacing code on block writes, R4 with a ready delay
    for (int p = 0; p < 4; p++) send(1'b1, 2'(p), p + 1, 1'b0);
    // R6: single writes under each pacing code
    for (int p = 0; p < 4; p++) send(1'b0, 2'(p), 0, 1'b0);
    // R7: request held valid during a transfer, then back to back
    send(1'b1, 2'd2, 0, 1'b1);
    send(1'b1, 2'd0, 0, 1'b1);
    // R4: write-ready held high for random lengths, mixed traffic
    for (int t = 0; t < 24; t++)
      send(1'($urandom), 2'($urandom), int'($urandom_range(0, 9)), 1'($urandom));
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule